// File: doc/BRIEF.md
# SPI clock and chip-select sequencer

This block is the timing core of an SPI master. From a programmed divisor it derives the serial clock, at the system clock divided by 2×(div+1). It applies the clock polarity and phase settings and tells the shift engine, through two strobes, on which edges to sample and on which to launch data. It also owns the chip-select vector. One line, picked by an index, is driven to the inverse of its per-line default level. The other lines stay at their defaults.

The shift engine raises a request when a frame is ready. The sequencer accepts it with a one-cycle acknowledge, frames the serial clock with four delays counted in whole serial-clock periods, and pulses a done strobe after the last edge. Those four delays are: CS setup before the first edge, CS release after the last edge, minimum CS-inactive time, and the gap between held frames. A chip-select policy input chooses one of three behaviours: release CS after every frame, hold it between frames, or leave the lines at their default levels.

Top module: `spi_sck_cs_seq`

## Requirements
- R1: One SCK half period lasts div+1 clock cycles. A frame has exactly 2×N SCK edges, where N is the frame-bits input and a value of 0 means 16.
- R2: Outside a frame, SCK rests at the polarity bit (clock-mode bit 1). SCK is back at that level when frame-done is asserted.
- R3: Clock-mode bit 0 is the phase bit. With phase 0, the sample strobe fires on leading edges (SCK leaves its rest level) and the launch strobe on trailing edges. With phase 1 this is reversed. Each edge has exactly one strobe, never both, so each frame has N samples and N launches.
- R4: While CS is asserted, the line named by the CS index shows the inverse of its default bit. Every other line, and every line when CS is not asserted, shows its default bit.
- R5: The first SCK edge of a frame that asserts CS comes (2×setup+1)×(div+1) cycles after CS asserts.
- R6: CS is released 2×release×(div+1) cycles after the last SCK edge of a frame. With a release of 0, CS releases on the same cycle as that edge.
- R7: After CS is released, it stays inactive for 2×rest×(div+1)+1 cycles before it asserts again for a frame that is already waiting.
- R8: Policy encoding: 0 is automatic (CS released after every frame), 2 is hold, 3 is off. The value 1 behaves as automatic.
- R9: In hold policy, CS stays asserted between frames. The first edge of the next frame comes 1+(2×gap+1)×(div+1) cycles after the last edge of the previous one.
- R10: If the policy leaves hold while CS is held idle, CS releases 2×release×(div+1) cycles after the first clock edge that sees the new policy.
- R11: In policy off, the CS vector equals the default vector on every cycle, and frames still run with normal SCK timing.
- R12: The acknowledge is a one-cycle pulse that appears together with CS assertion. Frame-done is a one-cycle pulse that appears together with the final SCK edge.
- R13: A frame request and a change of policy away from hold may arrive in the same cycle while CS is held. The frame is then accepted on the next edge, CS stays asserted through that frame, and the release follows its last edge as in R6.
- R14: While reset is high, SCK is low, every CS line is high, and the acknowledge, done and strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIVW | Clock divisor; half period is div+1 cycles |
| cfg_clk_mode | input | 2 | Bit 0 phase, bit 1 polarity |
| cfg_cs_sel | input | SELW | Index of the line to assert |
| cfg_cs_idle | input | NCS | Inactive level of each CS line |
| cfg_cs_policy | input | 2 | 0/1 automatic, 2 hold, 3 off |
| cfg_dly_setup | input | DLYW | CS-assert to first edge, in SCK periods |
| cfg_dly_release | input | DLYW | Last edge to CS release, in SCK periods |
| cfg_dly_rest | input | DLYW | Minimum CS-inactive time, in SCK periods |
| cfg_dly_gap | input | DLYW | Gap between held frames, in SCK periods |
| cfg_frame_bits | input | LENW | Bits per frame, 0 means 2^LENW |
| frm_req | input | 1 | Shift engine has a frame ready |
| frm_ack | output | 1 | Frame accepted (one cycle) |
| frm_done | output | 1 | Final SCK edge of the frame (one cycle) |
| sck_o | output | 1 | Serial clock |
| cs_o | output | NCS | Chip-select vector |
| sh_sample | output | 1 | Sample strobe on the SCK edge |
| sh_launch | output | 1 | Launch strobe on the SCK edge |

## Verification
The interesting collision is a new frame request and a drop of the hold policy in the same cycle while CS is held idle. Only one of the two can be acted on at the next edge. The bench provokes this by driving both inputs on the same falling edge after a held frame has finished. It then judges the outcome at the ports: the acknowledge must appear on the very next cycle, CS must not deassert before that frame's done pulse, and the release must trail the frame's last SCK edge by the programmed release delay.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HELD,
    ST_GAP,
    ST_REL,
    ST_REST
  } seq_st_e;

  localparam logic [1:0] POLICY_HOLD = 2'd2;
  localparam logic [1:0] POLICY_OFF  = 2'd3;

  function automatic logic cs_on_in(seq_st_e s);
    return (s == ST_SETUP) || (s == ST_XFER) || (s == ST_HELD) ||
           (s == ST_GAP) || (s == ST_REL);
  endfunction

endpackage

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
  parameter int DIVW = 12,
  parameter int HW   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [DIVW-1:0] div,
  output logic            tick,
  output logic [HW-1:0]   hcnt
);
  logic [DIVW-1:0] cnt_q;
  logic [HW-1:0]   hcnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      hcnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q  <= '0;
      hcnt_q <= hcnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == div);
  assign hcnt = hcnt_q;
endmodule

// File: rtl/spi_seq_sckgen.sv
module spi_seq_sckgen (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic pha,
  input  logic in_xfer,
  input  logic edge_en,
  input  logic edge_odd,
  output logic sck,
  output logic smp,
  output logic lch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sck <= 1'b0;
      smp <= 1'b0;
      lch <= 1'b0;
    end else begin
      smp <= 1'b0;
      lch <= 1'b0;
      if (edge_en) begin
        sck <= ~sck;
        smp <= (edge_odd == pha);
        lch <= (edge_odd != pha);
      end else if (!in_xfer) begin
        sck <= pol;
      end
    end
  end
endmodule

// File: rtl/spi_seq_csdrv.sv
module spi_seq_csdrv #(
  parameter int NCS  = 4,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            drive,
  input  logic [SELW-1:0] sel,
  input  logic [NCS-1:0]  idle,
  output logic [NCS-1:0]  cs
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) cs[i] <= 1'b1;
      else     cs[i] <= idle[i] ^ (drive && (sel == SELW'(i)));
    end
  end
endmodule

// File: rtl/spi_sck_cs_seq.sv
module spi_sck_cs_seq
  import spi_seq_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int DIVW = 12,
  parameter int DLYW = 8,
  parameter int LENW = 4,
  localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [1:0]      cfg_clk_mode,
  input  logic [SELW-1:0] cfg_cs_sel,
  input  logic [NCS-1:0]  cfg_cs_idle,
  input  logic [1:0]      cfg_cs_policy,
  input  logic [DLYW-1:0] cfg_dly_setup,
  input  logic [DLYW-1:0] cfg_dly_release,
  input  logic [DLYW-1:0] cfg_dly_rest,
  input  logic [DLYW-1:0] cfg_dly_gap,
  input  logic [LENW-1:0] cfg_frame_bits,
  input  logic            frm_req,
  output logic            frm_ack,
  output logic            frm_done,
  output logic            sck_o,
  output logic [NCS-1:0]  cs_o,
  output logic            sh_sample,
  output logic            sh_launch
);
  localparam int HW = ((DLYW > LENW) ? DLYW : LENW) + 2;

  seq_st_e st_q, st_nxt;
  logic [SELW-1:0] sel_q, sel_nxt;
  logic [HW-1:0] tgt, hcnt;
  logic tick, last, accept, hold_pol, edge_en;
  logic ack_q, done_q;
  seq_st_e after_rel;

  spi_seq_tick #(.DIVW(DIVW), .HW(HW)) u_tick (
    .clk(clk), .rst(rst), .clr(st_nxt != st_q), .div(cfg_div),
    .tick(tick), .hcnt(hcnt)
  );

  always_comb begin
    case (st_q)
      ST_SETUP: tgt = HW'(cfg_dly_setup) << 1;
      ST_GAP:   tgt = HW'(cfg_dly_gap) << 1;
      ST_REL:   tgt = HW'(cfg_dly_release) << 1;
      ST_REST:  tgt = HW'(cfg_dly_rest) << 1;
      ST_XFER:  tgt = (cfg_frame_bits == '0) ? (HW'(1) << (LENW + 1))
                                             : (HW'(cfg_frame_bits) << 1);
      default:  tgt = '0;
    endcase
  end

  assign last      = tick && (hcnt == tgt - 1'b1);
  assign hold_pol  = (cfg_cs_policy == POLICY_HOLD);
  assign after_rel = (cfg_dly_rest != '0) ? ST_REST : ST_IDLE;

  always_comb begin
    st_nxt = st_q;
    accept = 1'b0;
    case (st_q)
      ST_IDLE:
        if (frm_req) begin
          accept = 1'b1;
          st_nxt = (cfg_dly_setup != '0) ? ST_SETUP : ST_XFER;
        end
      ST_SETUP, ST_GAP:
        if (last) st_nxt = ST_XFER;
      ST_XFER:
        if (last) begin
          if (hold_pol)                  st_nxt = ST_HELD;
          else if (cfg_dly_release != '0) st_nxt = ST_REL;
          else                           st_nxt = after_rel;
        end
      ST_HELD:
        if (frm_req) begin
          accept = 1'b1;
          st_nxt = (cfg_dly_gap != '0) ? ST_GAP : ST_XFER;
        end else if (!hold_pol) begin
          st_nxt = (cfg_dly_release != '0) ? ST_REL : after_rel;
        end
      ST_REL:
        if (last) st_nxt = after_rel;
      ST_REST:
        if (last) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign sel_nxt = (accept && st_q == ST_IDLE) ? cfg_cs_sel : sel_q;
  assign edge_en = (st_q == ST_XFER) && tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      sel_q  <= sel_nxt;
      ack_q  <= accept;
      done_q <= edge_en && last;
    end
  end

  spi_seq_sckgen u_sck (
    .clk(clk), .rst(rst), .pol(cfg_clk_mode[1]), .pha(cfg_clk_mode[0]),
    .in_xfer(st_q == ST_XFER), .edge_en(edge_en), .edge_odd(hcnt[0]),
    .sck(sck_o), .smp(sh_sample), .lch(sh_launch)
  );

  spi_seq_csdrv #(.NCS(NCS), .SELW(SELW)) u_cs (
    .clk(clk), .rst(rst),
    .drive(cs_on_in(st_nxt) && (cfg_cs_policy != POLICY_OFF)),
    .sel(sel_nxt), .idle(cfg_cs_idle), .cs(cs_o)
  );

  assign frm_ack  = ack_q;
  assign frm_done = done_q;
endmodule

// File: rtl/spi_sck_cs_seq_chk.sv
module spi_sck_cs_seq_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     cfg_clk_mode,
  input logic [1:0]     cfg_cs_policy,
  input logic [NCS-1:0] cfg_cs_idle,
  input logic           frm_ack,
  input logic           frm_done,
  input logic           sck_o,
  input logic [NCS-1:0] cs_o,
  input logic           sh_sample,
  input logic           sh_launch
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sh_sample && sh_launch)); // R3

  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (sh_sample || sh_launch) |-> (sck_o != $past(sck_o))); // R1

  AST_SAMPLE_PHASE: assert property (@(posedge clk) disable iff (rst)
    sh_sample |-> ((sck_o != cfg_clk_mode[1]) == !cfg_clk_mode[0])); // R3

  AST_DONE_AT_REST: assert property (@(posedge clk) disable iff (rst)
    frm_done |-> (sck_o == cfg_clk_mode[1])); // R2

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_cs_policy) == 2'd3) |-> (cs_o == $past(cfg_cs_idle))); // R11

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    frm_ack |=> !frm_ack); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> !frm_done); // R12
endmodule

bind spi_sck_cs_seq spi_sck_cs_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .cfg_clk_mode(cfg_clk_mode),
  .cfg_cs_policy(cfg_cs_policy), .cfg_cs_idle(cfg_cs_idle),
  .frm_ack(frm_ack), .frm_done(frm_done), .sck_o(sck_o), .cs_o(cs_o),
  .sh_sample(sh_sample), .sh_launch(sh_launch)
);

// File: tb/spi_sck_cs_seq_test.sv
`timescale 1ns/1ps
module spi_sck_cs_seq_test;
  typedef struct packed {
    logic [11:0] dv;
    logic [7:0]  ds, dr, di, dg;
    logic        pol, pha;
    logic [3:0]  nb;
    logic [1:0]  pm;
    logic [1:0]  sel;
    logic [3:0]  idle;
  } ent_t;

  localparam ent_t TBL [0:5] = '{
    '{12'd1, 8'd1, 8'd1, 8'd1, 8'd0, 1'b0, 1'b0, 4'd8, 2'd0, 2'd0, 4'hF},
    '{12'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1, 1'b1, 4'd4, 2'd0, 2'd2, 4'hF},
    '{12'd2, 8'd2, 8'd3, 8'd1, 8'd2, 1'b0, 1'b1, 4'd5, 2'd2, 2'd1, 4'hD},
    '{12'd0, 8'd1, 8'd0, 8'd2, 8'd0, 1'b1, 1'b0, 4'd0, 2'd1, 2'd3, 4'hF},
    '{12'd1, 8'd1, 8'd1, 8'd1, 8'd1, 1'b0, 1'b0, 4'd3, 2'd3, 2'd0, 4'hA},
    '{12'd3, 8'd0, 8'd2, 8'd0, 8'd0, 1'b1, 1'b1, 4'd2, 2'd2, 2'd3, 4'h0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] cfg_div;
  logic [1:0] cfg_clk_mode, cfg_cs_sel, cfg_cs_policy;
  logic [3:0] cfg_cs_idle, cfg_frame_bits;
  logic [7:0] cfg_dly_setup, cfg_dly_release, cfg_dly_rest, cfg_dly_gap;
  logic frm_req = 1'b0;
  logic frm_ack, frm_done, sck_o, sh_sample, sh_launch;
  logic [3:0] cs_o;

  int t = 0, n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  spi_sck_cs_seq uut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_clk_mode(cfg_clk_mode),
    .cfg_cs_sel(cfg_cs_sel), .cfg_cs_idle(cfg_cs_idle), .cfg_cs_policy(cfg_cs_policy),
    .cfg_dly_setup(cfg_dly_setup), .cfg_dly_release(cfg_dly_release),
    .cfg_dly_rest(cfg_dly_rest), .cfg_dly_gap(cfg_dly_gap),
    .cfg_frame_bits(cfg_frame_bits), .frm_req(frm_req), .frm_ack(frm_ack),
    .frm_done(frm_done), .sck_o(sck_o), .cs_o(cs_o),
    .sh_sample(sh_sample), .sh_launch(sh_launch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    t++;
  endtask

  task automatic set_cfg(input ent_t e);
    cfg_div = e.dv; cfg_dly_setup = e.ds; cfg_dly_release = e.dr;
    cfg_dly_rest = e.di; cfg_dly_gap = e.dg; cfg_clk_mode = {e.pol, e.pha};
    cfg_frame_bits = e.nb; cfg_cs_policy = e.pm; cfg_cs_sel = e.sel;
    cfg_cs_idle = e.idle;
  endtask

  task automatic run_entry(input ent_t e);
    int hp, nbe, f, acks, edges, smp, lch, align_bad, space_bad, n_on, n_off;
    int t_on[2], t_off[2], t_first[2], t_last[2], t_ack[2], t_done[2];
    logic prev_sck, prev_as, as_now;
    logic [3:0] cs_seen;
    hp = int'(e.dv) + 1;
    nbe = (e.nb == 0) ? 16 : int'(e.nb);
    f = 0; acks = 0; edges = 0; smp = 0; lch = 0; align_bad = 0; space_bad = 0;
    n_on = 0; n_off = 0; cs_seen = e.idle;
    t_on = '{0, 0}; t_off = '{0, 0}; t_first = '{0, 0}; t_last = '{0, 0};
    t_ack = '{0, 0}; t_done = '{0, 0};
    set_cfg(e);
    repeat (3) step();
    chk(sck_o == e.pol, "R2 idle level", sck_o, e.pol);
    prev_sck = sck_o;
    prev_as = (cs_o != e.idle);
    frm_req = 1'b1;
    for (int g = 0; g < 4000; g++) begin
      step();
      as_now = (cs_o != e.idle);
      if (as_now && !prev_as && n_on < 2) begin t_on[n_on] = t; n_on++; cs_seen = cs_o; end
      if (!as_now && prev_as && n_off < 2) begin t_off[n_off] = t; n_off++; end
      if (frm_ack) begin
        if (acks < 2) t_ack[acks] = t;
        acks++;
        if (acks == 2) frm_req = 1'b0;
      end
      if (sck_o != prev_sck && f < 2) begin
        if (edges == 0) t_first[f] = t;
        else if (t - t_last[f] != hp) space_bad++;
        t_last[f] = t;
        edges++;
      end
      if (sh_sample) begin
        smp++;
        if ((sck_o != e.pol) != !e.pha) align_bad++;
      end
      if (sh_launch) lch++;
      if (frm_done && f < 2) begin
        t_done[f] = t;
        chk(edges == 2 * nbe, "R1 edges per frame", edges, 2 * nbe);
        chk(smp == nbe && lch == nbe, "R3 strobe counts", smp + lch, 2 * nbe);
        chk(sck_o == e.pol, "R2 level at done", sck_o, e.pol);
        chk(t_done[f] == t_last[f], "R12 done with last edge", t_done[f], t_last[f]);
        f++; edges = 0; smp = 0; lch = 0;
      end
      prev_sck = sck_o;
      prev_as = as_now;
      if (f == 2 && (e.pm >= 2'd2 || n_off == 2)) break;
    end
    chk(f == 2, "R12 frames completed", f, 2);
    chk(space_bad == 0, "R1 half period", space_bad, 0);
    chk(align_bad == 0, "R3 sample on phase edge", align_bad, 0);
    if (e.pm == 2'd3) begin
      chk(n_on == 0, "R11 off keeps defaults", n_on, 0);
    end else begin
      chk(cs_seen == (e.idle ^ (4'b1 << e.sel)), "R4 selected line level", cs_seen,
          e.idle ^ (4'b1 << e.sel));
      chk(t_first[0] - t_on[0] == (2 * e.ds + 1) * hp, "R5 setup delay",
          t_first[0] - t_on[0], (2 * e.ds + 1) * hp);
      chk(t_ack[0] == t_on[0], "R12 ack with CS", t_ack[0], t_on[0]);
    end
    if (e.pm == 2'd0 || e.pm == 2'd1) begin
      chk(n_on == 2 && n_off == 2, "R8 release per frame", n_on * 10 + n_off, 22);
      chk(t_off[0] - t_last[0] == 2 * e.dr * hp, "R6 release delay",
          t_off[0] - t_last[0], 2 * e.dr * hp);
      chk(t_on[1] - t_off[0] == 2 * e.di * hp + 1, "R7 inactive time",
          t_on[1] - t_off[0], 2 * e.di * hp + 1);
    end
    if (e.pm == 2'd2) begin
      int tp;
      chk(n_on == 1 && n_off == 0, "R9 CS held", n_on * 10 + n_off, 10);
      chk(t_first[1] - t_last[0] == 1 + (2 * e.dg + 1) * hp, "R9 held gap",
          t_first[1] - t_last[0], 1 + (2 * e.dg + 1) * hp);
      cfg_cs_policy = 2'd0;
      tp = t;
      for (int g = 0; g < 4000; g++) begin
        step();
        if (cs_o == e.idle) break;
      end
      chk(t - tp == 1 + 2 * e.dr * hp, "R10 leave hold", t - tp, 1 + 2 * e.dr * hp);
    end
    repeat (2 * (e.dr + e.di) * hp + 4) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    set_cfg(TBL[0]);
    cfg_cs_idle = 4'h5;
    cfg_clk_mode = 2'b10;
    repeat (3) step();
    chk(sck_o == 1'b0, "R14 sck in reset", sck_o, 0);
    chk(cs_o == 4'hF, "R14 cs in reset", cs_o, 4'hF);
    chk(!frm_ack && !frm_done && !sh_sample && !sh_launch, "R14 pulses in reset",
        {frm_ack, frm_done, sh_sample, sh_launch}, 0);
    rst = 1'b0;
    repeat (2) step();
    chk(cs_o == 4'h5, "R4 defaults when inactive", cs_o, 4'h5);
    chk(sck_o == 1'b1, "R2 rest after reset", sck_o, 1);

    for (int i = 0; i < 6; i++) run_entry(TBL[i]);

    // R13: request and hold exit in the same cycle
    begin
      ent_t c;
      int tp, t_ack2, t_lastedge, t_off2, early;
      logic prev_sck;
      bit got_done;
      c = '{12'd0, 8'd0, 8'd1, 8'd0, 8'd0, 1'b0, 1'b0, 4'd2, 2'd2, 2'd0, 4'hF};
      set_cfg(c);
      repeat (3) step();
      frm_req = 1'b1;
      for (int g = 0; g < 200; g++) begin step(); if (frm_ack) break; end
      frm_req = 1'b0;
      for (int g = 0; g < 200; g++) begin step(); if (frm_done) break; end
      repeat (3) step();
      cfg_cs_policy = 2'd0;
      frm_req = 1'b1;
      tp = t; t_ack2 = 0; t_lastedge = 0; t_off2 = 0; early = 0; got_done = 0;
      prev_sck = sck_o;
      for (int g = 0; g < 400; g++) begin
        step();
        if (frm_ack) begin t_ack2 = t; frm_req = 1'b0; end
        if (sck_o != prev_sck) t_lastedge = t;
        if (frm_done) got_done = 1;
        if (cs_o == 4'hF) begin
          if (!got_done) early++;
          t_off2 = t;
          break;
        end
        prev_sck = sck_o;
      end
      chk(t_ack2 == tp + 1, "R13 frame wins", t_ack2 - tp, 1);
      chk(early == 0 && got_done, "R13 CS held through frame", early, 0);
      chk(t_off2 - t_lastedge == 2, "R13 release after frame", t_off2 - t_lastedge, 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule